// File: doc/BRIEF.md
# SPI Transmit/Receive CRC Accumulator

This block keeps two running cyclic redundancy checks for a serial peripheral engine. One accumulates over the bits the engine shifts out and the other over the bits it shifts in. The engine gives one strobe per serial bit together with the outgoing and incoming bit values. The block advances both checks by one bit on each such strobe. The generator polynomial is held in a writable register. A width control chooses whether the checks run as 8-bit or 16-bit codes.

Software reaches the block through a small word-wide register port. It can write the control and polynomial registers and read back all four registers. The two results can only be read. Each time the enable bit is written with 1, both results are cleared, so the host clears them before a transfer. When the engine reports that it is running in audio-stream mode, the checks stay frozen. A read taken while the engine is busy is returned with a stale marker, because the value may be mid-frame.

Top module: `spi_crc_unit`

## Requirements
- R1: After a synchronous reset, both CRC results, the enable bit and the width bit read as 0, and the polynomial register reads 0x0007.
- R2: Register port map, selected by `reg_addr`: 0 is control (bit 0 enable, bit 1 wide mode, other bits read 0), 1 is the polynomial, 2 is the transmit CRC and 3 is the receive CRC. Read data and `reg_rvalid` appear on the clock after `reg_rd`. A write to address 2 or 3 changes nothing.
- R3: A write to control with bit 0 set clears both CRC results to 0 on the next clock, even if the enable bit was already 1. A write with bit 0 clear does not clear the results.
- R4: In wide mode, each step computes f = input bit XOR CRC bit 15, shifts the CRC left by one with 0 entering bit 0, and then XORs the full 16-bit polynomial into it when f is 1. Bits are taken most significant first. There is no reflection and no final XOR.
- R5: In narrow mode, the same step uses CRC bit 7 as the feedback bit and only the low 8 polynomial bits. Bits 15:8 of both results stay 0 after each step and read as 0 while narrow mode is selected.
- R6: A result advances only on a clock where `bit_stb` is 1, the enable bit is 1 and `i2s_mode` is 0. On every other clock without a clear, both results hold their value.
- R7: The transmit result is fed only by `tx_bit` and the receive result only by `rx_bit`. The two results are independent.
- R8: `rd_stale` comes out with the read data and equals the value of `busy` on the clock where `reg_rd` was sampled.
- R9: If a clear write and an active bit strobe fall on the same clock, the clear wins and both results are 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One pulse per serial bit from the engine |
| tx_bit | input | 1 | Bit being shifted out |
| rx_bit | input | 1 | Bit being shifted in |
| busy | input | 1 | Engine is mid-transfer |
| i2s_mode | input | 1 | Engine is in audio-stream mode; CRC frozen |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| reg_rvalid | output | 1 | Read data valid |
| rd_stale | output | 1 | Read was taken while busy |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high on the same clock. They also assume that every input is at a defined level on every clock outside reset, and that the width bit is changed only through a control write. The stimulus drives each register access as a single one-clock pulse, never combines a read with a write, and changes all inputs only on the falling clock edge. The only deliberate overlap of two actions is the clear-versus-strobe case, which is driven on purpose.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL  = 2'd0,
    ADR_POLY  = 2'd1,
    ADR_TXCRC = 2'd2,
    ADR_RXCRC = 2'd3
  } crc_addr_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_WIDE_BIT = 1;
  localparam int LANES        = 2;
endpackage

// File: rtl/spi_crc_lane.sv
module spi_crc_lane #(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic         wide,
  input  logic         din,
  input  logic [W-1:0] poly,
  output logic [W-1:0] crc
);
  localparam logic [W-1:0] NMASK = {{(W-NW){1'b0}}, {NW{1'b1}}};

  logic [W-1:0] crc_q, crc_nxt;
  logic         fb;

  always_comb begin
    fb      = din ^ (wide ? crc_q[W-1] : crc_q[NW-1]);
    crc_nxt = {crc_q[W-2:0], 1'b0} ^ (fb ? poly : '0);
    if (!wide) crc_nxt = crc_nxt & NMASK;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= '0;
    else if (step)  crc_q <= crc_nxt;
  end

  assign crc = crc_q;
endmodule

// File: rtl/spi_crc_regs.sv
module spi_crc_regs
  import spi_crc_pkg::*;
#(
  parameter int           W        = 16,
  parameter int           NW       = 8,
  parameter logic [W-1:0] POLY_RST = 16'h0007
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  input  logic              busy,
  input  logic [W-1:0]      tx_crc,
  input  logic [W-1:0]      rx_crc,
  output logic              crc_en,
  output logic              wide,
  output logic [W-1:0]      poly,
  output logic              clr,
  output logic [W-1:0]      reg_rdata,
  output logic              reg_rvalid,
  output logic              rd_stale
);
  localparam logic [W-1:0] NMASK = {{(W-NW){1'b0}}, {NW{1'b1}}};

  logic         en_q, wide_q;
  logic [W-1:0] poly_q, rd_mux, vis_mask;
  logic         wr_ctrl;

  assign wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
  assign clr     = wr_ctrl && reg_wdata[CTL_EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      wide_q <= 1'b0;
      poly_q <= POLY_RST;
    end else if (reg_wr) begin
      if (reg_addr == ADR_CTRL) begin
        en_q   <= reg_wdata[CTL_EN_BIT];
        wide_q <= reg_wdata[CTL_WIDE_BIT];
      end
      if (reg_addr == ADR_POLY) poly_q <= reg_wdata;
    end
  end

  assign vis_mask = wide_q ? '1 : NMASK;

  always_comb begin
    unique case (crc_addr_e'(reg_addr))
      ADR_CTRL:  rd_mux = {{(W-2){1'b0}}, wide_q, en_q};
      ADR_POLY:  rd_mux = poly_q;
      ADR_TXCRC: rd_mux = tx_crc & vis_mask;
      ADR_RXCRC: rd_mux = rx_crc & vis_mask;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
      rd_stale   <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      rd_stale   <= reg_rd && busy;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  assign crc_en = en_q;
  assign wide   = wide_q;
  assign poly   = poly_q;
endmodule

// File: rtl/spi_crc_unit.sv
module spi_crc_unit
  import spi_crc_pkg::*;
#(
  parameter int           W        = 16,
  parameter int           NW       = 8,
  parameter logic [W-1:0] POLY_RST = 16'h0007
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              tx_bit,
  input  logic              rx_bit,
  input  logic              busy,
  input  logic              i2s_mode,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              reg_rvalid,
  output logic              rd_stale
);
  logic         crc_en, wide, clr, step;
  logic [W-1:0] poly, tx_crc, rx_crc;
  logic [LANES-1:0] lane_din;
  logic [W-1:0]     lane_crc [LANES];

  assign step     = bit_stb && crc_en && !i2s_mode;
  assign lane_din = {rx_bit, tx_bit};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    spi_crc_lane #(.W(W), .NW(NW)) lane_i (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .step (step),
      .wide (wide),
      .din  (lane_din[g]),
      .poly (poly),
      .crc  (lane_crc[g])
    );
  end

  assign tx_crc = lane_crc[0];
  assign rx_crc = lane_crc[1];

  spi_crc_regs #(.W(W), .NW(NW), .POLY_RST(POLY_RST)) regs_i (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .busy       (busy),
    .tx_crc     (tx_crc),
    .rx_crc     (rx_crc),
    .crc_en     (crc_en),
    .wide       (wide),
    .poly       (poly),
    .clr        (clr),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .rd_stale   (rd_stale)
  );
endmodule

// File: rtl/spi_crc_chk.sv
module spi_crc_chk #(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         bit_stb,
  input logic         i2s_mode,
  input logic         busy,
  input logic         reg_wr,
  input logic         reg_rd,
  input logic [1:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] reg_rdata,
  input logic         reg_rvalid,
  input logic         rd_stale,
  input logic [W-1:0] tx_crc,
  input logic [W-1:0] rx_crc,
  input logic         crc_en,
  input logic         wide
);
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (tx_crc == '0) && (rx_crc == '0));

  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[0]) |=> (tx_crc == '0) && (rx_crc == '0));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!(bit_stb && crc_en && !i2s_mode) && !(reg_wr && reg_addr == 2'd0 && reg_wdata[0]))
      |=> $stable(tx_crc) && $stable(rx_crc));

  a_r2_rvalid_on: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);

  a_r2_rvalid_off: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> !reg_rvalid);

  a_r5_narrow_upper: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !wide && reg_addr[1]) |=> (reg_rdata[W-1:NW] == '0));

  a_r8_stale: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> (rd_stale == $past(busy)));
endmodule

bind spi_crc_unit spi_crc_chk #(.W(W), .NW(NW)) chk_i (.*);

// File: tb/spi_crc_unit_tb_top.sv
`timescale 1ns/1ps
module spi_crc_unit_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        bit_stb = 0, tx_bit = 0, rx_bit = 0, busy = 0, i2s_mode = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [1:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        reg_rvalid, rd_stale;

  int total = 0, bad = 0;
  bit done = 0;

  logic [15:0] m_tx = 0, m_rx = 0, m_poly = 16'h0007;
  logic        m_en = 0, m_wide = 0;

  always #2.5 clk = ~clk;

  spi_crc_unit dut_i (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .tx_bit(tx_bit), .rx_bit(rx_bit),
    .busy(busy), .i2s_mode(i2s_mode), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .rd_stale(rd_stale)
  );

  function automatic logic [15:0] m_step(input logic [15:0] c, input logic b,
                                         input logic [15:0] p, input logic w);
    logic f;
    logic [15:0] n;
    f = b ^ (w ? c[15] : c[7]);
    n = {c[14:0], 1'b0} ^ (f ? p : 16'h0);
    if (!w) n[15:8] = 8'h0;
    return n;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (a == 2'd0) begin
      m_en = d[0]; m_wide = d[1];
      if (d[0]) begin m_tx = 0; m_rx = 0; end
    end else if (a == 2'd1) m_poly = d;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    chk("R2 rvalid", {15'h0, reg_rvalid}, 16'h1);
    d = reg_rdata;
  endtask

  task automatic feed(input logic [15:0] tw, input logic [15:0] rw, input int n,
                      input logic stb);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      bit_stb = stb; tx_bit = tw[i]; rx_bit = rw[i];
      if (stb && m_en && !i2s_mode) begin
        m_tx = m_step(m_tx, tw[i], m_poly, m_wide);
        m_rx = m_step(m_rx, rw[i], m_poly, m_wide);
      end
    end
    @(negedge clk);
    bit_stb = 0;
  endtask

  task automatic read_both(input string tag);
    logic [15:0] d;
    rd(2'd2, d); chk({tag, " tx"}, d, m_wide ? m_tx : {8'h0, m_tx[7:0]});
    rd(2'd3, d); chk({tag, " rx"}, d, m_wide ? m_rx : {8'h0, m_rx[7:0]});
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd2, d); chk("R1 tx", d, 16'h0);
    rd(2'd3, d); chk("R1 rx", d, 16'h0);
    rd(2'd0, d); chk("R1 ctrl", d, 16'h0);
    rd(2'd1, d); chk("R1 poly", d, 16'h0007);
  endtask

  task automatic t_map();
    logic [15:0] d;
    wr(2'd1, 16'h1021);
    rd(2'd1, d); chk("R2 poly", d, 16'h1021);
    wr(2'd2, 16'hFFFF); wr(2'd3, 16'hBEEF);
    rd(2'd2, d); chk("R2 ro tx", d, 16'h0);
    rd(2'd3, d); chk("R2 ro rx", d, 16'h0);
    wr(2'd0, 16'h0002);
    rd(2'd0, d); chk("R2 ctrl", d, 16'h0002);
  endtask

  task automatic t_disabled();
    wr(2'd0, 16'h0002);
    feed(16'hFFFF, 16'hFFFF, 8, 1);
    read_both("R6 disabled");
  endtask

  task automatic t_crc16();
    wr(2'd0, 16'h0003);
    feed(16'hA5C3, 16'h1234, 16, 1);
    read_both("R4 R7 wide");
    feed(16'hFFFF, 16'h0000, 16, 1);
    read_both("R4 R7 wide2");
  endtask

  task automatic t_hold();
    feed(16'h5A5A, 16'hC3C3, 10, 0);
    read_both("R6 no strobe");
    i2s_mode = 1;
    feed(16'h5A5A, 16'hC3C3, 10, 1);
    i2s_mode = 0;
    read_both("R6 i2s");
  endtask

  task automatic t_crc8();
    wr(2'd1, 16'h0107);
    wr(2'd0, 16'h0001);
    feed(16'h005A, 16'h00FF, 8, 1);
    read_both("R5 narrow");
    feed(16'h00C3, 16'h0081, 8, 1);
    read_both("R5 narrow2");
  endtask

  task automatic t_width_mask();
    logic [15:0] d;
    wr(2'd1, 16'h8005);
    wr(2'd0, 16'h0003);
    feed(16'hF00D, 16'h0F0F, 16, 1);
    read_both("R4 pre-mask");
    wr(2'd0, 16'h0000);
    rd(2'd2, d); chk("R5 mask tx", d, {8'h0, m_tx[7:0]});
    rd(2'd3, d); chk("R5 mask rx", d, {8'h0, m_rx[7:0]});
  endtask

  task automatic t_clear();
    wr(2'd0, 16'h0003);
    feed(16'h1357, 16'h2468, 16, 1);
    read_both("R3 pre");
    wr(2'd0, 16'h0002);
    read_both("R3 no clear on 0");
    wr(2'd0, 16'h0003);
    feed(16'h00AB, 16'h00CD, 8, 1);
    wr(2'd0, 16'h0003);
    read_both("R3 re-clear");
  endtask

  task automatic t_clear_prio();
    feed(16'h00FF, 16'h00FF, 8, 1);
    @(negedge clk);
    bit_stb = 1; tx_bit = 1; rx_bit = 1;
    reg_wr = 1; reg_addr = 2'd0; reg_wdata = 16'h0003;
    @(negedge clk);
    bit_stb = 0; reg_wr = 0;
    m_tx = 0; m_rx = 0;
    read_both("R9 clear wins");
  endtask

  task automatic t_stale();
    logic [15:0] d;
    busy = 1;
    rd(2'd2, d);
    chk("R8 stale busy", {15'h0, rd_stale}, 16'h1);
    busy = 0;
    rd(2'd2, d);
    chk("R8 stale idle", {15'h0, rd_stale}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_map();
    t_disabled();
    t_crc16();
    t_hold();
    t_crc8();
    t_width_mask();
    t_clear();
    t_clear_prio();
    t_stale();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule